// File: doc/BRIEF.md
# Task-Indexed Page Translator

This block turns the 16-bit address of an 8-bit processor into a 20-bit physical address. Memory is split into 256-byte pages. An internal page table holds one entry for each page of each task. The index into that table is built by pure bit concatenation. A task-select register supplies the upper index bits and the processor page number (address bits 15:8) supplies the lower eight. Each task therefore owns a fixed, aligned group of 256 entries, and no base register or adder sits in the path. The selected entry's physical page number is placed above the unchanged low address byte.

Each entry also carries a write-protect bit. A processor write to a protected page is blocked from reaching memory, and it sets a sticky fault flag. Software clears that flag with a configuration command. The faulting instruction is never restarted.

The table is read one cycle ahead of use. The result is tagged with the index it was read for, so the output is marked valid only while the address and the task still match that tag. In practice the processor holds an address for at least two cycles, and the translation is ready from the second cycle. A configuration port loads the task register and the table entries, and it clears the fault flag.

Top module: `task_page_xlat`

## Requirements
- R1: While reset is applied and after it is released, the task register is 0, and `xlat_valid`, `phys_we` and `wr_fault` are 0 until a lookup has completed.
- R2: With an address held for two cycles, `phys_addr[19:8]` equals bits 11:0 of the table entry at index {task, cpu_addr[15:8]}, and `xlat_valid` is 1.
- R3: `phys_addr[7:0]` always equals `cpu_addr[7:0]`.
- R4: The same processor page maps through different entries for different tasks, taken from entry task*256 + page.
- R5: In the cycle in which `cpu_addr[15:8]` changes, `xlat_valid` is 0. It becomes 1 after one clock edge with the address held.
- R6: A task-select command (`cfg_op`=2'b00, task in `cfg_wdata[3:0]`) that changes the task makes `xlat_valid` 0 in the following cycle. The lookup for the new task is valid one cycle later.
- R7: An entry write (`cfg_op`=2'b01, index in `cfg_index`, write-protect in `cfg_wdata[12]`, page number in `cfg_wdata[11:0]`) is used by lookups from the next cycle. This includes the entry currently being translated, which updates without losing validity.
- R8: Entry writes never change the task register, whatever index or data they carry.
- R9: `phys_we` follows `cpu_we` on a valid translation of an unprotected page. It is 0 when the entry's write-protect bit is set.
- R10: A write to a protected page with a valid translation sets `wr_fault` from the next cycle. `wr_fault` then holds until a clear command (`cfg_op`=2'b10). If a new violation and a clear occur in the same cycle, the flag stays set.
- R11: A processor write while `xlat_valid` is 0 is suppressed, and it does not set `wr_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Processor logical address |
| cpu_we | input | 1 | Processor write strobe |
| cfg_we | input | 1 | Configuration command strobe |
| cfg_op | input | 2 | Command: 00 set task, 01 write entry, 10 clear fault, 11 none |
| cfg_index | input | 12 | Table index for entry writes ({task, page}) |
| cfg_wdata | input | 13 | Task number or entry data {wp, page number} |
| phys_addr | output | 20 | Translated physical address |
| xlat_valid | output | 1 | Translation matches the current address and task |
| phys_we | output | 1 | Write strobe passed on to physical memory |
| wr_fault | output | 1 | Sticky write-protect violation flag |

## Verification
Several properties are checked on every cycle by the assertions. The task register stays stable without a set command. A bypassed entry write lands in the lookup result. The fault flag is set by a violation, held without a clear, and dropped by a lone clear. A change of task always costs one invalid cycle, and no write strobe leaves the block without a valid translation. Other behaviours can only be shown by the bench's directed scenarios, because they depend on the contents of the table. These are the concatenated index (including the separation between tasks), the exact physical address values, the bubble when the page changes, and the fact that writes during an invalid cycle are dropped without a fault.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

  typedef enum logic [1:0] {
    CFG_SET_TASK  = 2'b00,
    CFG_WR_ENTRY  = 2'b01,
    CFG_CLR_FAULT = 2'b10,
    CFG_NONE      = 2'b11
  } cfg_op_e;

  localparam int DEF_TASK_W = 4;
  localparam int DEF_PAGE_W = 8;
  localparam int DEF_OFF_W  = 8;
  localparam int DEF_PPN_W  = 12;

endpackage

// File: rtl/tpx_rst_sync.sv
module tpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tpx_task_reg.sv
module tpx_task_reg #(
  parameter int TASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [TASK_W-1:0] set_val,
  output logic [TASK_W-1:0] task_q
);

  logic [TASK_W-1:0] task_d;

  always_comb begin
    task_d = task_q;
    if (set_en) task_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) task_q <= '0;
    else        task_q <= task_d;
  end

  // R8
  task_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(task_q));

endmodule

// File: rtl/tpx_page_table.sv
module tpx_page_table #(
  parameter int IDX_W   = 12,
  parameter int ENTRY_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [ENTRY_W-1:0] rd_data_q,
  output logic [IDX_W-1:0]   rd_idx_q,
  output logic               rd_done_q
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] rd_data_d;
  logic               same_slot;

  always_comb begin
    same_slot = wr_en && (wr_idx == rd_idx);
    rd_data_d = same_slot ? wr_data : mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data_q <= rd_data_d;
    rd_idx_q  <= rd_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_done_q <= 1'b0;
    else        rd_done_q <= 1'b1;
  end

  // R7
  bypass_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx) |=> (rd_data_q == $past(wr_data)));

endmodule

// File: rtl/tpx_guard.sv
module tpx_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_we,
  input  logic hit,
  input  logic wp,
  input  logic clr,
  output logic phys_we,
  output logic fault_q
);

  logic violation;
  logic fault_d;

  always_comb begin
    violation = cpu_we && hit && wp;
    phys_we   = cpu_we && hit && !wp;
    fault_d   = fault_q;
    if (clr)       fault_d = 1'b0;
    if (violation) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  // R10
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && hit && wp) |=> fault_q);

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q);

  // R10
  fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(cpu_we && hit && wp)) |=> !fault_q);

endmodule

// File: rtl/task_page_xlat.sv
module task_page_xlat #(
  parameter int TASK_W = tpx_pkg::DEF_TASK_W,
  parameter int PAGE_W = tpx_pkg::DEF_PAGE_W,
  parameter int OFF_W  = tpx_pkg::DEF_OFF_W,
  parameter int PPN_W  = tpx_pkg::DEF_PPN_W,
  localparam int CPU_AW  = PAGE_W + OFF_W,
  localparam int IDX_W   = TASK_W + PAGE_W,
  localparam int ENTRY_W = PPN_W + 1,
  localparam int PHYS_W  = PPN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_we,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_op,
  input  logic [IDX_W-1:0]   cfg_index,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic               xlat_valid,
  output logic               phys_we,
  output logic               wr_fault
);

  import tpx_pkg::*;

  logic               rst_i_n;
  logic               set_task;
  logic               wr_entry;
  logic               clr_fault;
  logic [TASK_W-1:0]  task_q;
  logic [IDX_W-1:0]   cur_idx;
  logic [ENTRY_W-1:0] pte_q;
  logic [IDX_W-1:0]   pte_idx_q;
  logic               pte_done_q;

  tpx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    set_task  = cfg_we && (cfg_op == CFG_SET_TASK);
    wr_entry  = cfg_we && (cfg_op == CFG_WR_ENTRY);
    clr_fault = cfg_we && (cfg_op == CFG_CLR_FAULT);
    cur_idx   = {task_q, cpu_addr[CPU_AW-1:OFF_W]};
  end

  tpx_task_reg #(.TASK_W(TASK_W)) u_task (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_en  (set_task),
    .set_val (cfg_wdata[TASK_W-1:0]),
    .task_q  (task_q)
  );

  tpx_page_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd_idx    (cur_idx),
    .wr_en     (wr_entry),
    .wr_idx    (cfg_index),
    .wr_data   (cfg_wdata),
    .rd_data_q (pte_q),
    .rd_idx_q  (pte_idx_q),
    .rd_done_q (pte_done_q)
  );

  always_comb begin
    xlat_valid = pte_done_q && (pte_idx_q == cur_idx);
    phys_addr  = {pte_q[PPN_W-1:0], cpu_addr[OFF_W-1:0]};
  end

  tpx_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cpu_we  (cpu_we),
    .hit     (xlat_valid),
    .wp      (pte_q[PPN_W]),
    .clr     (clr_fault),
    .phys_we (phys_we),
    .fault_q (wr_fault)
  );

  // R6
  task_bubble_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (set_task && cfg_wdata[TASK_W-1:0] != task_q) |=> !xlat_valid);

  // R11
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    phys_we |-> xlat_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_i_n |-> (!wr_fault && !xlat_valid && task_q == '0));

endmodule

// File: tb/task_page_xlat_bench.sv
`timescale 1ns/1ps
module task_page_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic        cfg_we;
  logic [1:0]  cfg_op;
  logic [11:0] cfg_index;
  logic [12:0] cfg_wdata;
  logic [19:0] phys_addr;
  logic        xlat_valid;
  logic        phys_we;
  logic        wr_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  task_page_xlat u_task_page_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_index(cfg_index),
    .cfg_wdata(cfg_wdata), .phys_addr(phys_addr), .xlat_valid(xlat_valid),
    .phys_we(phys_we), .wr_fault(wr_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [3:0] tsk, input logic [7:0] page,
                             input logic wp, input logic [11:0] ppn);
    cfg_we = 1'b1; cfg_op = 2'b01; cfg_index = {tsk, page}; cfg_wdata = {wp, ppn};
    @(negedge clk);
    cfg_we = 1'b0; cfg_op = 2'b11;
  endtask

  task automatic set_task(input logic [3:0] tsk);
    cfg_we = 1'b1; cfg_op = 2'b00; cfg_wdata = {9'd0, tsk};
    @(negedge clk);
    cfg_we = 1'b0; cfg_op = 2'b11;
  endtask

  task automatic clear_fault();
    cfg_we = 1'b1; cfg_op = 2'b10;
    @(negedge clk);
    cfg_we = 1'b0; cfg_op = 2'b11;
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_we = 1'b0;
    cfg_we = 1'b0; cfg_op = 2'b11; cfg_index = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, xlat_valid}, 32'd0);
    chk("R1 fault in reset", {31'd0, wr_fault}, 32'd0);
    chk("R1 phys_we in reset", {31'd0, phys_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    write_entry(4'h0, 8'h05, 1'b0, 12'hABC);
    look(16'h0577);
    chk("R1 task0 after reset", {12'd0, phys_addr}, 32'hABC77);
    chk("R1 fault after reset", {31'd0, wr_fault}, 32'd0);
  endtask

  task automatic t_translate();
    write_entry(4'h0, 8'h12, 1'b0, 12'h111);
    write_entry(4'h0, 8'h13, 1'b0, 12'h777);
    look(16'h12AB);
    chk("R2 translate", {12'd0, phys_addr}, 32'h111AB);
    chk("R2 valid", {31'd0, xlat_valid}, 32'd1);
    cpu_addr = 16'h12CD; #1;
    chk("R3 offset passthrough", {24'd0, phys_addr[7:0]}, 32'hCD);
    chk("R5 same page stays valid", {31'd0, xlat_valid}, 32'd1);
    @(negedge clk);
    cpu_addr = 16'h1344; #1;
    chk("R5 page change bubble", {31'd0, xlat_valid}, 32'd0);
    @(negedge clk);
    chk("R5 valid after hold", {31'd0, xlat_valid}, 32'd1);
    chk("R5 new page", {12'd0, phys_addr}, 32'h77744);
  endtask

  task automatic t_tasks();
    write_entry(4'h3, 8'h12, 1'b0, 12'h333);
    look(16'h12AB);
    set_task(4'h3);
    chk("R6 task change bubble", {31'd0, xlat_valid}, 32'd0);
    @(negedge clk);
    chk("R6 valid after task change", {31'd0, xlat_valid}, 32'd1);
    chk("R4 task3 entry", {12'd0, phys_addr}, 32'h333AB);
  endtask

  task automatic t_updates();
    write_entry(4'h3, 8'h12, 1'b0, 12'h3A5);
    chk("R7 bypass value", {12'd0, phys_addr}, 32'h3A5AB);
    chk("R7 bypass valid", {31'd0, xlat_valid}, 32'd1);
    write_entry(4'h3, 8'h40, 1'b0, 12'h040);
    write_entry(4'h5, 8'h12, 1'b0, 12'h555);
    look(16'h4001);
    chk("R7 next-cycle use", {12'd0, phys_addr}, 32'h04001);
    look(16'h12AB);
    chk("R8 task kept after writes", {12'd0, phys_addr}, 32'h3A5AB);
  endtask

  task automatic t_protect();
    write_entry(4'h3, 8'h20, 1'b1, 12'h222);
    look(16'h2000);
    cpu_we = 1'b1; #1;
    chk("R9 protected suppressed", {31'd0, phys_we}, 32'd0);
    @(negedge clk);
    cpu_we = 1'b0;
    chk("R10 fault set", {31'd0, wr_fault}, 32'd1);
    look(16'h12AB);
    cpu_we = 1'b1; #1;
    chk("R9 unprotected passes", {31'd0, phys_we}, 32'd1);
    @(negedge clk);
    cpu_we = 1'b0;
    chk("R10 fault sticky", {31'd0, wr_fault}, 32'd1);
    clear_fault();
    chk("R10 fault cleared", {31'd0, wr_fault}, 32'd0);
    look(16'h2000);
    cpu_we = 1'b1; cfg_we = 1'b1; cfg_op = 2'b10;
    @(negedge clk);
    cpu_we = 1'b0; cfg_we = 1'b0; cfg_op = 2'b11;
    chk("R10 set wins over clear", {31'd0, wr_fault}, 32'd1);
    clear_fault();
  endtask

  task automatic t_invalid_write();
    cpu_addr = 16'h12AB; cpu_we = 1'b1; #1;
    chk("R11 invalid write blocked", {31'd0, phys_we}, 32'd0);
    @(negedge clk);
    cpu_addr = 16'h2000; #1;
    chk("R11 protected invalid blocked", {31'd0, phys_we}, 32'd0);
    @(negedge clk);
    cpu_we = 1'b0;
    chk("R11 no fault from invalid", {31'd0, wr_fault}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_translate();
    t_tasks();
    t_updates();
    t_protect();
    t_invalid_write();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule